// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block decides when a processor core stops and when it starts again. Software requests the deepest sleep state by writing a one to a power-down request bit. The core's clock is then gated off at the end of the instruction that made the write. While the core is halted, the block forces the address-latch strobe and the program-fetch strobe low. The port registers are not touched, so they keep whatever values they last held.

The controller itself runs on an always-on reference clock. While the core clock is gated, it watches the external reset pin and the active-low external interrupt pins through synchronisers. Two kinds of wake are kept apart:

- **Reset-pin wake.** A high level on the reset pin reopens the core clock and raises a one-cycle request to restart execution at address zero.
- **Interrupt wake.** An interrupt pin held low reopens the core clock only when that pin's own enable and the global interrupt enable are both set. The block then emits a one-hot, one-cycle request naming the pin, so the core runs that handler and afterwards resumes at the instruction after the one that wrote the request bit.

The watchdog is deliberately not an input. With its clock stopped, it can never end the halt.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `core_clk_en_o` is 1, `strobe_low_o` is 0, `restart_zero_o` is 0 and `int_wake_o` is all zero.
- R2: A power-down write with no instruction-complete strobe does not halt the core. The halt (`core_clk_en_o` going to 0) happens at the first clock edge where `insn_done_i` is 1 while a power-down request is pending or being written in that same cycle.
- R3: While halted, `core_clk_en_o` is 0 and `strobe_low_o` is 1. Both take these values at the same edge.
- R4: While halted, a reset-pin level of 1 wakes the core on the third clock edge after it is applied (two synchronising stages with the default settings). At that edge `core_clk_en_o` becomes 1, `strobe_low_o` becomes 0, and `restart_zero_o` is 1 for exactly one cycle.
- R5: While halted, an interrupt pin `ext_int_n_i[k]` held at 0 with `int_en_i[k]` = 1 and `global_en_i` = 1 wakes the core on the third clock edge. At that edge `int_wake_o` has only bit k set, for one cycle, and `restart_zero_o` stays 0.
- R6: While halted, a low interrupt pin does not wake the core if its own enable is 0 or if `global_en_i` is 0.
- R7: If the reset pin and a qualified interrupt pin become active in the same cycle while halted, the reset wake wins. `restart_zero_o` pulses and `int_wake_o` stays zero.
- R8: If several qualified interrupt pins are low together, `int_wake_o` names the lowest-numbered pin (bit 0 has the highest priority).
- R9: Any wake clears the pending power-down request. A later instruction-complete strobe with no new write leaves the core running.
- R10: A reset-pin level of 1 while the core is running cancels a pending power-down request.
- R11: While the core is running, low qualified interrupt pins never raise `int_wake_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| pd_write_i | input | 1 | Core writes 1 to the power-down request bit |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| rst_pin_i | input | 1 | External reset pin level, active high, asynchronous |
| ext_int_n_i | input | N_INT | External interrupt pins, active low, asynchronous |
| int_en_i | input | N_INT | Per-pin interrupt enables |
| global_en_i | input | 1 | Global interrupt enable |
| core_clk_en_o | output | 1 | Core clock enable, 0 while halted |
| strobe_low_o | output | 1 | Forces the address-latch and fetch strobes low |
| restart_zero_o | output | 1 | One-cycle request to restart at address zero |
| int_wake_o | output | N_INT | One-hot, one-cycle interrupt wake request |

## Verification
Halt entry is tried two ways. In one, the request write and the completing instruction arrive in separate cycles; in the other, they arrive together. Together these show that the halt waits for the instruction boundary. Wake is tried with:

- the reset pin alone,
- a single qualified interrupt pin,
- two qualified pins at once,
- reset and interrupt together,
- low pins that lack their own enable or the global enable.

These patterns separate the address-zero restart from the interrupt resume, and they confirm both the priority order and the qualification. Further runs place reset-pin activity and interrupt activity in the running state. They show that a pending request is cancelled and that no wake is reported while the core is awake. Each wake is sampled both at its exact edge and one edge earlier, so the synchroniser latency is pinned down.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } pd_state_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pwrdn_wake_sel.sv
module pwrdn_wake_sel #(
  parameter int N_INT = 4
) (
  input  logic [N_INT-1:0] low_i,
  input  logic [N_INT-1:0] en_i,
  input  logic             global_i,
  output logic             any_o,
  output logic [N_INT-1:0] pick_o
);
  logic [N_INT-1:0] qual;

  always_comb begin
    qual   = low_i & en_i & {N_INT{global_i}};
    pick_o = '0;
    for (int i = N_INT - 1; i >= 0; i--) begin
      if (qual[i]) pick_o = N_INT'(1) << i;
    end
    any_o = |qual;
  end
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
#(
  parameter int N_INT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_write_i,
  input  logic             insn_done_i,
  input  logic             rst_wake_i,
  input  logic             int_any_i,
  input  logic [N_INT-1:0] int_pick_i,
  output logic             clk_en_o,
  output logic             strobe_low_o,
  output logic             restart_o,
  output logic [N_INT-1:0] int_wake_o
);
  pd_state_e state;
  logic      pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      pend         <= 1'b0;
      clk_en_o     <= 1'b1;
      strobe_low_o <= 1'b0;
      restart_o    <= 1'b0;
      int_wake_o   <= '0;
    end else begin
      restart_o  <= 1'b0;
      int_wake_o <= '0;
      unique case (state)
        ST_RUN: begin
          if (rst_wake_i) begin
            pend <= 1'b0;
          end else if (insn_done_i && (pend || pd_write_i)) begin
            state        <= ST_HALT;
            pend         <= 1'b1;
            clk_en_o     <= 1'b0;
            strobe_low_o <= 1'b1;
          end else if (pd_write_i) begin
            pend <= 1'b1;
          end
        end
        ST_HALT: begin
          if (rst_wake_i || int_any_i) begin
            state        <= ST_RUN;
            pend         <= 1'b0;
            clk_en_o     <= 1'b1;
            strobe_low_o <= 1'b0;
            if (rst_wake_i) restart_o  <= 1'b1;
            else            int_wake_o <= int_pick_i;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl #(
  parameter int N_INT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_write_i,
  input  logic             insn_done_i,
  input  logic             rst_pin_i,
  input  logic [N_INT-1:0] ext_int_n_i,
  input  logic [N_INT-1:0] int_en_i,
  input  logic             global_en_i,
  output logic             core_clk_en_o,
  output logic             strobe_low_o,
  output logic             restart_zero_o,
  output logic [N_INT-1:0] int_wake_o
);
  localparam int SYNC_W = N_INT + 1;

  logic [SYNC_W-1:0] raw_lvl;
  logic [SYNC_W-1:0] syn_lvl;
  logic              int_any;
  logic [N_INT-1:0]  int_pick;

  assign raw_lvl = {rst_pin_i, ~ext_int_n_i};

  pwrdn_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_lvl),
    .q_o (syn_lvl)
  );

  pwrdn_wake_sel #(.N_INT(N_INT)) u_sel (
    .low_i    (syn_lvl[N_INT-1:0]),
    .en_i     (int_en_i),
    .global_i (global_en_i),
    .any_o    (int_any),
    .pick_o   (int_pick)
  );

  pwrdn_fsm #(.N_INT(N_INT)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .pd_write_i   (pd_write_i),
    .insn_done_i  (insn_done_i),
    .rst_wake_i   (syn_lvl[N_INT]),
    .int_any_i    (int_any),
    .int_pick_i   (int_pick),
    .clk_en_o     (core_clk_en_o),
    .strobe_low_o (strobe_low_o),
    .restart_o    (restart_zero_o),
    .int_wake_o   (int_wake_o)
  );
endmodule

// File: rtl/pwrdn_wake_ctrl_chk.sv
module pwrdn_wake_ctrl_chk #(
  parameter int N_INT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_done_i,
  input logic             global_en_i,
  input logic             core_clk_en_o,
  input logic             strobe_low_o,
  input logic             restart_zero_o,
  input logic [N_INT-1:0] int_wake_o
);
  p_entry_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clk_en_o) |-> $past(insn_done_i));

  p_halt_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    !core_clk_en_o |-> strobe_low_o);

  p_restart_on_wake_r4: assert property (@(posedge clk) disable iff (rst)
    restart_zero_o |-> (core_clk_en_o && $past(!core_clk_en_o)));

  p_restart_single_r4: assert property (@(posedge clk) disable iff (rst)
    restart_zero_o |=> !restart_zero_o);

  p_int_on_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (|int_wake_o) |-> (core_clk_en_o && $past(!core_clk_en_o)));

  p_int_needs_global_r6: assert property (@(posedge clk) disable iff (rst)
    (|int_wake_o) |-> $past(global_en_i));

  p_reset_excludes_int_r7: assert property (@(posedge clk) disable iff (rst)
    restart_zero_o |-> (int_wake_o == '0));

  p_int_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(int_wake_o));
endmodule

bind pwrdn_wake_ctrl pwrdn_wake_ctrl_chk #(.N_INT(N_INT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .insn_done_i    (insn_done_i),
  .global_en_i    (global_en_i),
  .core_clk_en_o  (core_clk_en_o),
  .strobe_low_o   (strobe_low_o),
  .restart_zero_o (restart_zero_o),
  .int_wake_o     (int_wake_o)
);

// File: tb/pwrdn_wake_ctrl_bench.sv
module pwrdn_wake_ctrl_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pd_write = 1'b0;
  logic         insn_done = 1'b0;
  logic         rst_pin = 1'b0;
  logic [N-1:0] int_n = '1;
  logic [N-1:0] int_en = '0;
  logic         gen = 1'b0;
  logic         clk_en;
  logic         strobe_low;
  logic         restart;
  logic [N-1:0] wake;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwrdn_wake_ctrl #(.N_INT(N), .SYNC_STAGES(2)) u_pwrdn_wake_ctrl (
    .clk            (clk),
    .rst            (rst),
    .pd_write_i     (pd_write),
    .insn_done_i    (insn_done),
    .rst_pin_i      (rst_pin),
    .ext_int_n_i    (int_n),
    .int_en_i       (int_en),
    .global_en_i    (gen),
    .core_clk_en_o  (clk_en),
    .strobe_low_o   (strobe_low),
    .restart_zero_o (restart),
    .int_wake_o     (wake)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    rst_pin = 1'b0;
    int_n   = '1;
    tick(3);
  endtask

  task automatic enter_halt();
    pd_write  = 1'b1;
    insn_done = 1'b1;
    tick();
    pd_write  = 1'b0;
    insn_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 clk_en", 8'(clk_en), 8'h1);
    chk("R1 strobe", 8'(strobe_low), 8'h0);
    chk("R1 restart", 8'(restart), 8'h0);
    chk("R1 int_wake", 8'(wake), 8'h0);
  endtask

  task automatic t_entry();
    pd_write = 1'b1;
    tick();
    pd_write = 1'b0;
    chk("R2 write alone keeps running", 8'(clk_en), 8'h1);
    tick(2);
    chk("R2 still running before boundary", 8'(clk_en), 8'h1);
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
    chk("R2 halt at boundary", 8'(clk_en), 8'h0);
    chk("R3 strobes forced low", 8'(strobe_low), 8'h1);
    tick(4);
    chk("R3 halt holds", 8'(clk_en), 8'h0);
  endtask

  task automatic t_reset_wake();
    rst_pin = 1'b1;
    tick(2);
    chk("R4 not before third edge", 8'(clk_en), 8'h0);
    tick();
    chk("R4 clk_en", 8'(clk_en), 8'h1);
    chk("R4 strobe released", 8'(strobe_low), 8'h0);
    chk("R4 restart pulse", 8'(restart), 8'h1);
    chk("R4 no int wake", 8'(wake), 8'h0);
    rst_pin = 1'b0;
    tick();
    chk("R4 restart one cycle", 8'(restart), 8'h0);
    settle();
  endtask

  task automatic t_int_wake();
    int_en = 4'b0100;
    gen    = 1'b1;
    enter_halt();
    int_n = 4'b1011;
    tick(2);
    chk("R5 not before third edge", 8'(clk_en), 8'h0);
    tick();
    chk("R5 clk_en", 8'(clk_en), 8'h1);
    chk("R5 int_wake bit2", 8'(wake), 8'h04);
    chk("R5 no restart", 8'(restart), 8'h0);
    int_n = '1;
    tick();
    chk("R5 int_wake one cycle", 8'(wake), 8'h0);
    settle();
  endtask

  task automatic t_unqualified();
    enter_halt();
    int_en = 4'b1110;
    gen    = 1'b1;
    int_n  = 4'b1110;
    tick(6);
    chk("R6 own enable clear", 8'(clk_en), 8'h0);
    int_en = 4'b1111;
    gen    = 1'b0;
    tick(6);
    chk("R6 global enable clear", 8'(clk_en), 8'h0);
    chk("R6 no int wake", 8'(wake), 8'h0);
    int_n = '1;
    tick(3);
    rst_pin = 1'b1;
    tick(3);
    chk("R4 reset wake without global", 8'(restart), 8'h1);
    settle();
  endtask

  task automatic t_priority();
    int_en = '1;
    gen    = 1'b1;
    enter_halt();
    rst_pin = 1'b1;
    int_n   = 4'b1101;
    tick(3);
    chk("R7 reset wins restart", 8'(restart), 8'h1);
    chk("R7 reset wins no int", 8'(wake), 8'h0);
    settle();
  endtask

  task automatic t_lowest();
    int_en = '1;
    gen    = 1'b1;
    enter_halt();
    int_n = 4'b0101;
    tick(3);
    chk("R8 lowest index", 8'(wake), 8'h02);
    settle();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
    chk("R9 request cleared by wake", 8'(clk_en), 8'h1);
  endtask

  task automatic t_cancel();
    pd_write = 1'b1;
    tick();
    pd_write = 1'b0;
    rst_pin  = 1'b1;
    tick(3);
    settle();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
    chk("R10 pending request cancelled", 8'(clk_en), 8'h1);
  endtask

  task automatic t_run_int();
    int_en = '1;
    gen    = 1'b1;
    int_n  = 4'b0000;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R11 no wake while running", 8'(wake), 8'h0);
    end
    settle();
  endtask

  initial begin
    @(negedge clk);
    tick(2);
    rst = 1'b0;
    tick();
    t_reset();
    t_entry();
    t_reset_wake();
    t_int_wake();
    t_unqualified();
    t_priority();
    t_lowest();
    t_cancel();
    t_run_int();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule